// File: doc/BRIEF.md
# Memory Clock-Enable Power State Controller

This block sits on the device side of a graphics DRAM and follows the power state that the clock-enable pin, the decoded command stream and the bank status put the device in. A low clock enable sampled in the active state puts the device into one of two power-down states. If every bank is closed, the device goes to precharge power-down. If any bank is open, it goes to active power-down. From precharge power-down, an auto-refresh command taken with chip select low moves the device into self-refresh. Active power-down never leads to self-refresh.

The controller drives two enables. One is for the command/address input receivers. The other is for the clock receiver, which is switched off only in self-refresh. Leaving self-refresh is asynchronous: a high clock enable restores the active state at the outputs without waiting for a clock edge. The two ordinary power-down states are left only on a clock edge.

Dropping clock enable during a burst is a protocol error. The controller refuses the transition and raises a sticky flag. The clock-enable level present when reset is released is held as the termination select bit.

Top module: `cke_power_ctrl`

## Requirements
- R1: While and after reset, `pstate` is 0 (active), `rx_en` and `clk_rx_en` are 1 and `violation` is 0.
- R2: In the active state, a low `cke` with no burst and no effectively open bank gives `pstate` 1 (precharge power-down) after that rising edge.
- R3: In the active state, a low `cke` with no burst and at least one effectively open bank gives `pstate` 2 (active power-down) after that rising edge.
- R4: In state 1 with `cke` low, `refresh_cmd` high together with `cs_n` low gives `pstate` 3 (self-refresh) after the edge. If `cs_n` is high, the request is ignored and the state stays 1.
- R5: In state 2, `refresh_cmd` has no effect and the state never becomes 3.
- R6: In states 1 and 2, `rx_en` is 0 and `clk_rx_en` is 1. In state 3, both are 0.
- R7: In state 3, a high `cke` makes `pstate` read 0 and turns both enables on immediately, with no clock edge. The internal state follows on the next rising edge.
- R8: States 1 and 2 return to 0 only on a rising edge at which `cke` is high.
- R9: A low `cke` sampled in state 0 while `burst_busy` is high keeps state 0 and sets `violation`. The flag stays set until reset.
- R10: `term_sel` holds the `cke` level present when `rst_n` is released.
- R11: Self-refresh entry marks every bank as closed. A bank counts as open again only after its `bank_open` bit has been seen low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampled memory clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cke | input | 1 | Clock-enable level |
| cs_n | input | 1 | Chip select, active low |
| refresh_cmd | input | 1 | Decoded auto-refresh strobe |
| bank_open | input | NUM_BANKS | Per-bank open flags |
| burst_busy | input | 1 | Read, write or snoop burst in progress |
| pstate | output | 2 | 0 active, 1 precharge power-down, 2 active power-down, 3 self-refresh |
| rx_en | output | 1 | Command/address input receiver enable |
| clk_rx_en | output | 1 | Clock receiver enable |
| violation | output | 1 | Sticky flag for clock enable dropped during a burst |
| term_sel | output | 1 | Termination select captured at reset release |

## Verification
A wrong state register shows on `pstate` and on the receiver enables one edge after the triggering `cke` sample. The one exception is the self-refresh exit, which must show within the same cycle, before any edge. The bench sweeps all 256 bank patterns through power-down entry and exit, so a wrong open-bank decision shows as the wrong power-down code. A bank mask that is not cleared on self-refresh entry shows only on the next power-down entry, as active instead of precharge power-down.

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl #(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 refresh_cmd,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 burst_busy,
  output logic [1:0]           pstate,
  output logic                 rx_en,
  output logic                 clk_rx_en,
  output logic                 violation,
  output logic                 term_sel
);

  localparam logic [1:0] ST_ACT = 2'd0;
  localparam logic [1:0] ST_PPD = 2'd1;
  localparam logic [1:0] ST_APD = 2'd2;
  localparam logic [1:0] ST_SR  = 2'd3;

  logic [1:0]           st, st_nx;
  logic [NUM_BANKS-1:0] stale;
  logic                 any_open, sr_wake, sr_enter, burst_err;

  assign any_open  = |(bank_open & ~stale);
  assign sr_wake   = (st == ST_SR) && cke;
  assign sr_enter  = (st == ST_PPD) && !cke && refresh_cmd && !cs_n;
  assign burst_err = (st == ST_ACT) && !cke && burst_busy;

  always_comb begin
    st_nx = st;
    case (st)
      ST_ACT: if (!cke && !burst_busy) st_nx = any_open ? ST_APD : ST_PPD;
      ST_PPD: if (cke) st_nx = ST_ACT;
              else if (sr_enter) st_nx = ST_SR;
      ST_APD: if (cke) st_nx = ST_ACT;
      ST_SR:  if (cke) st_nx = ST_ACT;
      default: st_nx = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_ACT;
      stale     <= '0;
      violation <= 1'b0;
    end else begin
      st        <= st_nx;
      stale     <= sr_enter ? {NUM_BANKS{1'b1}} : (stale & bank_open);
      violation <= violation | burst_err;
    end
  end

  always_ff @(posedge rst_n) term_sel <= cke;

  assign pstate    = sr_wake ? ST_ACT : st;
  assign rx_en     = (pstate == ST_ACT);
  assign clk_rx_en = (pstate != ST_SR);

  a_r2_ppd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACT && !cke && !burst_busy && !any_open) |=> (st == ST_PPD));
  a_r3_apd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACT && !cke && !burst_busy && any_open) |=> (st == ST_APD));
  a_r4_sr_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PPD && !cke && refresh_cmd && !cs_n) |=> (st == ST_SR));
  a_r5_no_sr_from_apd: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_APD) |=> (st != ST_SR));
  a_r7_sr_exit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SR && cke) |=> (st == ST_ACT));
  a_r8_pd_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_PPD || st == ST_APD) && cke) |=> (st == ST_ACT));
  a_r9_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACT && !cke && burst_busy) |=> (violation && st == ST_ACT));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

endmodule

// File: tb/cke_power_ctrl_test.sv
module cke_power_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1, refresh_cmd = 1'b0, burst_busy = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic [1:0] pstate;
  logic rx_en, clk_rx_en, violation, term_sel;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  cke_power_ctrl #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .refresh_cmd(refresh_cmd),
    .bank_open(bank_open), .burst_busy(burst_busy), .pstate(pstate), .rx_en(rx_en),
    .clk_rx_en(clk_rx_en), .violation(violation), .term_sel(term_sel));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic cke_lvl);
    @(posedge clk); #2;
    rst_n = 1'b0; cke = cke_lvl; burst_busy = 0; refresh_cmd = 0; cs_n = 1; bank_open = '0;
    cyc();
    chk("R1 state in reset", pstate, 0);
    #3 rst_n = 1'b1;
    #1 chk("R10 term_sel", term_sel, cke_lvl);
    cke = 1'b1;
    cyc();
  endtask

  initial begin
    do_reset(1'b0);
    chk("R1 state", pstate, 0);
    chk("R1 rx_en", rx_en, 1);
    chk("R1 clk_rx_en", clk_rx_en, 1);
    chk("R1 violation", violation, 0);
    do_reset(1'b1);

    for (int p = 0; p < (1 << NB); p++) begin
      bank_open = NB'(p);
      cke = 0; cyc();
      chk(p == 0 ? "R2 ppd entry" : "R3 apd entry", pstate, p == 0 ? 1 : 2);
      chk("R6 rx off in pd", rx_en, 0);
      chk("R6 clk rx on in pd", clk_rx_en, 1);
      cyc();
      chk("R8 stays in pd while cke low", pstate, p == 0 ? 1 : 2);
      cke = 1; #1;
      chk("R8 no exit before edge", pstate, p == 0 ? 1 : 2);
      cyc();
      chk("R8 clocked exit", pstate, 0);
    end

    bank_open = 8'h10; cke = 0; cyc();
    refresh_cmd = 1; cs_n = 0; cyc(); cyc();
    chk("R5 refresh ignored in apd", pstate, 2);
    refresh_cmd = 0; cs_n = 1; cke = 1; cyc();
    chk("R8 apd exit", pstate, 0);

    bank_open = '0; cke = 0; cyc();
    chk("R2 ppd", pstate, 1);
    refresh_cmd = 1; cs_n = 1; cyc();
    chk("R4 cs high ignored", pstate, 1);
    cs_n = 0; bank_open = 8'h01; cyc();
    refresh_cmd = 0; cs_n = 1;
    chk("R4 sr entry", pstate, 3);
    chk("R6 rx off in sr", rx_en, 0);
    chk("R6 clk rx off in sr", clk_rx_en, 0);
    cyc();
    chk("R4 stays in sr", pstate, 3);
    @(negedge clk); cke = 1; #1;
    chk("R7 async exit state", pstate, 0);
    chk("R7 async exit rx", rx_en, 1);
    chk("R7 async exit clk rx", clk_rx_en, 1);
    cyc();
    chk("R7 registered active", pstate, 0);
    cke = 0; cyc();
    chk("R11 stale bank treated closed", pstate, 1);
    cke = 1; cyc();
    bank_open = '0; cyc();
    bank_open = 8'h01; cke = 0; cyc();
    chk("R11 reopened bank counts", pstate, 2);
    cke = 1; cyc();

    bank_open = '0; burst_busy = 1; cke = 0; cyc();
    chk("R9 held active", pstate, 0);
    chk("R9 violation set", violation, 1);
    burst_busy = 0; cke = 1; cyc(); cyc();
    chk("R9 sticky", violation, 1);
    do_reset(1'b1);
    chk("R1 violation cleared", violation, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule